// File: doc/BRIEF.md
# Enqueue Command Ring Consumer

This block is the hardware side of an eight-slot ring through which software hands commands to a queueing engine. Software fills a slot through a write port. The slot holds a data body and a verb byte. Software then tells the block that new work exists. The block then delivers the slots in ring order on a valid/ready stream, one per clock. It keeps a consumer index that software reads to learn which slots it may reuse.

Software announces new work in one of three ways, chosen by a 2-bit mode setting. Mode 0 writes the producer index to a register port. Mode 1 writes it to a mirror port. In mode 2 no index is written at all. Instead the block watches the verb byte of the slot at its producer position. When the top bit of that byte equals the expected phase, the slot counts as produced. The expected phase starts at 1 and inverts each time the producer index wraps from the last slot to slot 0. Software therefore writes the verb byte last, as the command code ORed with the current phase in bit 7.

Occupancy is the producer index minus the consumer index modulo the ring size, so at most seven slots are ever in use. A level interrupt is high while occupancy is at or below a programmed threshold. It tells software that room has opened up.

Top module: `qring_enq`

## Requirements
- R1: After reset, the consumer index is 0, no entry is offered, the expected phase is 1, the producer mode is 0 and the threshold is 0, so the interrupt is high.
- R2: In mode 0, a producer index write makes every slot from the consumer index up to, but not including, the new index available. The first one is offered in the cycle after the write, with its slot number, verb byte and body.
- R3: The consumer index advances by one, wrapping from 7 to 0, in the cycle after each accepted transfer (valid and ready both high). While an offered entry waits for ready, the consumer index and the offered slot stay unchanged.
- R4: In mode 1 only mirror writes update the producer index and register writes are ignored. In mode 0 mirror writes are ignored. In mode 2 both are ignored.
- R5: In mode 2, the slot at the producer position is taken when bit 7 of its verb byte equals the expected phase. It is offered two cycles after the verb write. A body write alone, or a verb with the other phase, does not produce it.
- R6: The expected phase inverts whenever the producer index wraps past slot 7, so a consumed slot still holding the old phase is never taken a second time.
- R7: The ring never holds more than seven entries. In mode 2 a matching slot is not taken while the next producer position equals the consumer index.
- R8: An index write in mode 0 or 1 that would lower the occupancy (move the producer backwards) is ignored.
- R9: A mode write takes effect only while the ring is empty. The code 3 is never accepted.
- R10: The interrupt output is high exactly when the occupancy is less than or equal to the threshold register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_mode | input | 2 | Requested producer mode (0 register, 1 mirror, 2 phase bit) |
| thr_wr | input | 1 | Threshold write strobe |
| thr_val | input | 3 | New interrupt threshold |
| ent_wr_body | input | 1 | Write body of slot ent_idx |
| ent_wr_verb | input | 1 | Write verb byte of slot ent_idx |
| ent_idx | input | 3 | Slot written |
| ent_body | input | 32 | Body data |
| ent_verb | input | 8 | Verb byte (bit 7 is the phase bit) |
| pi_reg_wr | input | 1 | Producer index write, register path |
| pi_mir_wr | input | 1 | Producer index write, mirror path |
| pi_wdata | input | 3 | Producer index value |
| out_valid | output | 1 | An entry is offered |
| out_ready | input | 1 | Downstream accepts the entry |
| out_idx | output | 3 | Slot number of the offered entry |
| out_verb | output | 8 | Verb byte of the offered entry |
| out_body | output | 32 | Body of the offered entry |
| ci_o | output | 3 | Consumer index |
| irq | output | 1 | Occupancy at or below threshold |

## Verification
The bench fills the ring in phase mode until only the full-ring guard holds back a matching slot. A design without the guard would see producer equal consumer, report an empty ring and lose seven commands. It then drains past the wrap and leaves a stale phase-1 verb in a consumed slot. A design that does not invert the phase would replay that command. Further checks cover a backward index write, which a naive design would accept and so shrink the occupancy. They also cover a mode switch attempted while entries are pending, which would strand the entries or make the block follow the wrong notification path. The interrupt is sampled right at the boundary between occupancy seven and six.

// File: rtl/qring_pkg.sv
package qring_pkg;
  localparam int VERB_W = 8;
  localparam int VBIT   = VERB_W - 1;

  typedef enum logic [1:0] {
    PM_REG    = 2'd0,
    PM_MIRROR = 2'd1,
    PM_PHASE  = 2'd2
  } pmode_e;
endpackage

// File: rtl/qring_store.sv
module qring_store
  import qring_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_body,
  input  logic              wr_verb,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_body_d,
  input  logic [VERB_W-1:0] wr_verb_d,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_body,
  output logic [VERB_W-1:0] rd_verb,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic              probe_vbit
);
  logic [DATA_W-1:0] body_q [DEPTH];
  logic [VERB_W-1:0] verb_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic body_en, verb_en;
    assign body_en = wr_body && (wr_idx == IDX_W'(s));
    assign verb_en = wr_verb && (wr_idx == IDX_W'(s));

    // payload storage carries no reset
    always_ff @(posedge clk) begin
      if (body_en) body_q[s] <= wr_body_d;
    end

    // verb bytes cleared so no phase-1 match exists after reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       verb_q[s] <= '0;
      else if (verb_en) verb_q[s] <= wr_verb_d;
    end
  end

  assign rd_body    = body_q[rd_idx];
  assign rd_verb    = verb_q[rd_idx];
  assign probe_vbit = verb_q[probe_idx][VBIT];
endmodule

// File: rtl/qring_prod.sv
module qring_prod
  import qring_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_mode,
  input  logic             pi_reg_wr,
  input  logic             pi_mir_wr,
  input  logic [IDX_W-1:0] pi_wdata,
  input  logic [IDX_W-1:0] ci,
  input  logic             probe_vbit,
  output logic [IDX_W-1:0] pi,
  output pmode_e           mode
);
  logic [IDX_W-1:0] pi_q, pi_n;
  logic             phase_q, phase_n;
  pmode_e           mode_q, mode_n;
  logic             empty, idx_wr, fwd_ok, vb_hit;
  logic [IDX_W-1:0] fill_old, fill_new, pi_inc;

  assign empty    = (pi_q == ci);
  assign pi_inc   = pi_q + 1'b1;
  assign fill_old = pi_q - ci;
  assign fill_new = pi_wdata - ci;
  assign fwd_ok   = (fill_new >= fill_old);
  assign idx_wr   = ((mode_q == PM_REG) && pi_reg_wr) ||
                    ((mode_q == PM_MIRROR) && pi_mir_wr);
  assign vb_hit   = (mode_q == PM_PHASE) && (probe_vbit == phase_q) &&
                    (pi_inc != ci);

  always_comb begin
    mode_n = mode_q;
    if (cfg_wr && empty && (cfg_mode != 2'd3)) mode_n = pmode_e'(cfg_mode);
    pi_n = pi_q;
    if (idx_wr && fwd_ok) pi_n = pi_wdata;
    else if (vb_hit)      pi_n = pi_inc;
    // a numerically lower producer index means the ring wrapped
    phase_n = phase_q ^ (pi_n < pi_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pi_q    <= '0;
      phase_q <= 1'b1;
      mode_q  <= PM_REG;
    end else begin
      pi_q    <= pi_n;
      phase_q <= phase_n;
      mode_q  <= mode_n;
    end
  end

  assign pi   = pi_q;
  assign mode = mode_q;
endmodule

// File: rtl/qring_cons.sv
module qring_cons #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] pi,
  input  logic             out_ready,
  input  logic             thr_wr,
  input  logic [IDX_W-1:0] thr_val,
  output logic             out_valid,
  output logic [IDX_W-1:0] ci,
  output logic             irq
);
  logic [IDX_W-1:0] ci_q, ci_n, thr_q, thr_n, fill;
  logic             take;

  assign out_valid = (pi != ci_q);
  assign take      = out_valid && out_ready;
  assign fill      = pi - ci_q;

  always_comb begin
    ci_n  = take ? ci_q + 1'b1 : ci_q;
    thr_n = thr_wr ? thr_val : thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ci_q  <= '0;
      thr_q <= '0;
    end else begin
      ci_q  <= ci_n;
      thr_q <= thr_n;
    end
  end

  assign ci  = ci_q;
  assign irq = (fill <= thr_q);
endmodule

// File: rtl/qring_enq.sv
module qring_enq
  import qring_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_mode,
  input  logic              thr_wr,
  input  logic [IDX_W-1:0]  thr_val,
  input  logic              ent_wr_body,
  input  logic              ent_wr_verb,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic [DATA_W-1:0] ent_body,
  input  logic [VERB_W-1:0] ent_verb,
  input  logic              pi_reg_wr,
  input  logic              pi_mir_wr,
  input  logic [IDX_W-1:0]  pi_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_idx,
  output logic [VERB_W-1:0] out_verb,
  output logic [DATA_W-1:0] out_body,
  output logic [IDX_W-1:0]  ci_o,
  output logic              irq
);
  logic [IDX_W-1:0] pi_q, ci_q;
  logic             probe_vbit;
  pmode_e           mode_q;

  qring_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_body(ent_wr_body), .wr_verb(ent_wr_verb), .wr_idx(ent_idx),
    .wr_body_d(ent_body), .wr_verb_d(ent_verb),
    .rd_idx(ci_q), .rd_body(out_body), .rd_verb(out_verb),
    .probe_idx(pi_q), .probe_vbit(probe_vbit)
  );

  qring_prod #(.IDX_W(IDX_W)) u_prod (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .pi_reg_wr(pi_reg_wr), .pi_mir_wr(pi_mir_wr), .pi_wdata(pi_wdata),
    .ci(ci_q), .probe_vbit(probe_vbit),
    .pi(pi_q), .mode(mode_q)
  );

  qring_cons #(.IDX_W(IDX_W)) u_cons (
    .clk(clk), .rst_n(rst_n),
    .pi(pi_q), .out_ready(out_ready),
    .thr_wr(thr_wr), .thr_val(thr_val),
    .out_valid(out_valid), .ci(ci_q), .irq(irq)
  );

  assign out_idx = ci_q;
  assign ci_o    = ci_q;
endmodule

// File: rtl/qring_enq_chk.sv
module qring_enq_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] pi,
  input logic [IDX_W-1:0] ci,
  input logic [1:0]       mode,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_idx
);
  // R3
  ci_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (ci == IDX_W'($past(ci) + 1'b1)));

  // R3
  ci_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready) |=> $stable(ci));

  // R3
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx)));

  // R7
  no_lost_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R9
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pi != ci) |=> $stable(mode));

  // R9
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
endmodule

bind qring_enq qring_enq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pi(pi_q), .ci(ci_q), .mode(mode_q),
  .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx)
);

// File: tb/tb_qring_enq.sv
module tb_qring_enq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, thr_wr, ent_wr_body, ent_wr_verb;
  logic        pi_reg_wr, pi_mir_wr, out_ready;
  logic [1:0]  cfg_mode;
  logic [2:0]  thr_val, ent_idx, pi_wdata;
  logic [31:0] ent_body;
  logic [7:0]  ent_verb;
  logic        out_valid, irq;
  logic [2:0]  out_idx, ci_o;
  logic [7:0]  out_verb;
  logic [31:0] out_body;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  qring_enq dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .thr_wr(thr_wr), .thr_val(thr_val),
    .ent_wr_body(ent_wr_body), .ent_wr_verb(ent_wr_verb), .ent_idx(ent_idx),
    .ent_body(ent_body), .ent_verb(ent_verb),
    .pi_reg_wr(pi_reg_wr), .pi_mir_wr(pi_mir_wr), .pi_wdata(pi_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_verb(out_verb), .out_body(out_body), .ci_o(ci_o), .irq(irq)
  );

  // {ready delay[40:39], command code[38:32], body[31:0]}
  localparam logic [40:0] VEC [10] = '{
    {2'd0, 7'h01, 32'hDEAD_0001}, {2'd1, 7'h02, 32'h1234_5678},
    {2'd3, 7'h7F, 32'hFFFF_FFFF}, {2'd0, 7'h00, 32'h0000_0000},
    {2'd2, 7'h55, 32'hA5A5_A5A5}, {2'd1, 7'h2A, 32'h5A5A_5A5A},
    {2'd0, 7'h33, 32'h0BAD_F00D}, {2'd3, 7'h44, 32'hCAFE_0007},
    {2'd1, 7'h66, 32'h8000_0000}, {2'd2, 7'h11, 32'h0000_0001}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_inputs();
    cfg_wr = 0; thr_wr = 0; ent_wr_body = 0; ent_wr_verb = 0;
    pi_reg_wr = 0; pi_mir_wr = 0; out_ready = 0;
    cfg_mode = 0; thr_val = 0; ent_idx = 0; ent_body = 0; ent_verb = 0; pi_wdata = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    tick(3);
    rst_n = 1;
    tick(1);
  endtask

  task automatic put(input logic [2:0] idx, input logic [31:0] b, input logic [7:0] v,
                     input bit wb, input bit wv);
    ent_idx = idx; ent_body = b; ent_verb = v; ent_wr_body = wb; ent_wr_verb = wv;
    tick(1);
    ent_wr_body = 0; ent_wr_verb = 0;
  endtask

  task automatic pub(input bit mirror, input logic [2:0] v);
    pi_wdata = v; pi_reg_wr = !mirror; pi_mir_wr = mirror;
    tick(1);
    pi_reg_wr = 0; pi_mir_wr = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    cfg_mode = m; cfg_wr = 1; tick(1); cfg_wr = 0;
  endtask

  task automatic set_thr(input logic [2:0] t);
    thr_val = t; thr_wr = 1; tick(1); thr_wr = 0;
  endtask

  task automatic pop();
    out_ready = 1; tick(1); out_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0] p;
    do_reset();
    // R1 reset state
    chk("R1 ci", ci_o, 0);
    chk("R1 valid", out_valid, 0);
    chk("R1 irq", irq, 1);

    // ---- phase-bit mode ----
    set_mode(2);
    put(0, 32'h0000_00A0, 8'h00, 1, 0);
    tick(3);
    chk("R5 body only", out_valid, 0);
    put(0, 32'h0, 8'h80 | 8'h05, 0, 1);
    chk("R5 not yet", out_valid, 0);
    tick(1);
    chk("R5 taken", out_valid, 1);
    chk("R5 idx", out_idx, 0);
    chk("R5 verb", out_verb, 8'h85);
    chk("R5 body", out_body, 32'h0000_00A0);
    pop();
    chk("R1 phase start 1 ci", ci_o, 1);
    put(1, 32'h0, 8'h0C, 0, 1);                 // wrong phase
    tick(3);
    chk("R5 wrong phase", out_valid, 0);

    set_thr(6);
    for (int k = 1; k < 8; k++) put(k[2:0], 32'h100 + k, 8'h80 | (8'h10 + k[7:0]), 1, 1);
    put(0, 32'h100, 8'h10, 1, 1);               // new phase 0, blocked by guard
    tick(4);
    chk("R7 ring not full", out_valid, 1);
    chk("R10 irq fill7", irq, 0);
    set_mode(0);                                // must be rejected
    for (int k = 1; k <= 8; k++) begin
      p = k[2:0];
      chk("R6 drain idx", out_idx, p);
      chk("R6 drain verb", out_verb, (k == 8) ? 8'h10 : (8'h90 + k[7:0]));
      pop();
      if (k == 1) begin
        tick(2);
        chk("R7 guard released fill7", irq, 0);
      end
      if (k == 2) chk("R10 irq fill6", irq, 1);
    end
    tick(3);
    chk("R6 stale phase not retaken", out_valid, 0);
    pub(0, 5);
    chk("R9 mode kept, reg write ignored", out_valid, 0);
    put(1, 32'h0, 8'h2A, 0, 1);
    tick(1);
    chk("R6 new phase taken", out_valid, 1);
    chk("R6 new phase verb", out_verb, 8'h2A);
    pop();

    // ---- register mode, table driven ----
    do_reset();
    chk("R1 ci after reset", ci_o, 0);
    chk("R1 valid after reset", out_valid, 0);
    p = 0;
    for (int k = 0; k < 10; k++) begin
      put(p, VEC[k][31:0], {1'b0, VEC[k][38:32]}, 1, 1);
      pub(0, p + 3'd1);
      chk("R2 valid", out_valid, 1);
      chk("R2 idx", out_idx, p);
      chk("R2 verb", out_verb, {1'b0, VEC[k][38:32]});
      chk("R2 body", out_body, VEC[k][31:0]);
      tick(int'(VEC[k][40:39]));
      chk("R3 held idx", out_idx, p);
      pop();
      p = p + 3'd1;
      chk("R3 ci step", ci_o, p);
    end

    // ---- mirror mode ----
    set_mode(1);
    pub(0, 5);
    chk("R4 reg ignored in mode1", out_valid, 0);
    pub(1, 5);
    chk("R4 mirror in mode1", out_valid, 1);
    pub(1, 3);                                  // backwards
    pop(); pop(); pop();
    chk("R8 backward ignored ci", ci_o, 5);
    chk("R8 drained", out_valid, 0);
    set_mode(3);
    pub(1, 6);
    chk("R9 code3 ignored", out_valid, 1);
    pop();
    set_mode(0);
    pub(1, 7);
    chk("R4 mirror ignored in mode0", out_valid, 0);
    chk("R10 irq empty", irq, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule